// File: doc/BRIEF.md
# Watchdog External Reset Pulse Generator

This block produces the pulse that leaves the chip when a watchdog runs out. A one-cycle expiry strobe starts the pulse. It then lasts a whole number of microseconds, counted on a 1 MHz tick enable. One 32-bit configuration word holds the pulse length and two state bits. One bit sets the polarity of the asserted level. The other bit selects push-pull drive or open-drain drive. Open drain is emulated with an output-enable that drives the pin only while the pulse is asserted.

The two state bits are protected against stray writes. They change only when the top byte of a write carries one of four fixed key values. Any other top byte leaves both bits as they are, but the length field of the same write is still stored. A pulse that is already running is not restarted by a further expiry strobe. A change to the length field during a pulse does not alter that pulse.

Top module: `extrst_pulse_gen`

## Requirements
- R1: After reset, the configuration read returns 0x000000FF, which means length 0xFF (a 256 µs pulse), active-low polarity and open-drain drive. `pulseOut` is 1 and `pulseOe` is 0.
- R2: Every write stores `wrData[19:0]` as the length field. On read, bits 19:0 return that field and bits 29:20 return 0.
- R3: Bit 31 of the read word reports active-high polarity. A write with top byte 0xA5 sets this bit, and a write with top byte 0x5A clears it.
- R4: Bit 30 of the read word reports push-pull drive. A write with top byte 0xA8 sets this bit, and a write with top byte 0x8A clears it.
- R5: A write whose top byte is any other value leaves bits 31 and 30 unchanged, and its bits 19:0 are still stored.
- R6: An expiry strobe while idle asserts the pulse from the next clock cycle. For a length field N, the pulse deasserts on the clock edge of the (N+1)th tick seen while it is asserted. A tick in the cycle of the strobe is not counted.
- R7: An expiry strobe while the pulse is asserted neither extends nor restarts the pulse.
- R8: `pulseOut` equals bit 31 while the pulse is asserted, and equals the inverse of bit 31 otherwise.
- R9: With push-pull drive, `pulseOe` is always 1. With open-drain drive, `pulseOe` is 1 only while the pulse is asserted.
- R10: A write to the length field during a pulse does not change the length of that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| expire | input | 1 | Watchdog expiry strobe |
| tick | input | 1 | 1 MHz tick enable, one cycle wide |
| wrEn | input | 1 | Configuration write strobe |
| wrData | input | 32 | Configuration write data |
| rdData | output | 32 | Configuration read data |
| pulseOut | output | 1 | Pin value |
| pulseOe | output | 1 | Pin output-enable |

## Verification
A wrong polarity bit, drive bit or length field shows on `rdData` in the cycle right after the write that caused it. A wrong polarity bit or drive bit also shows on the idle level of `pulseOut` or `pulseOe` in that same cycle. A fault in the down-counter or in the pulse state stays hidden until the pulse ends. It then shows as a tick count that is too high or too low at deassertion. For this reason the bench counts ticks over whole pulses, with several tick spacings. It also disturbs pulses with extra strobes and mid-pulse writes.

// File: rtl/extrst_pkg.sv
package extrst_pkg;

  localparam logic [7:0] KEY_POL_HIGH  = 8'hA5;
  localparam logic [7:0] KEY_POL_LOW   = 8'h5A;
  localparam logic [7:0] KEY_DRV_PUSH  = 8'hA8;
  localparam logic [7:0] KEY_DRV_OPEN  = 8'h8A;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRIVE = 1'b1
  } pulseState_t;

  typedef struct packed {
    logic loadWidth;
    logic polToHigh;
    logic polToLow;
    logic drvToPush;
    logic drvToOpen;
    logic loadCount;
    logic decCount;
  } dpStrobes_t;

endpackage

// File: rtl/extrst_ctrl.sv
module extrst_ctrl
  import extrst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       expire,
  input  logic       tick,
  input  logic       wrEn,
  input  logic [7:0] topByte,
  input  logic       countZero,
  output dpStrobes_t strb,
  output logic       active
);

  pulseState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb = '0;
    strb.loadWidth = wrEn;
    strb.polToHigh = wrEn && (topByte == KEY_POL_HIGH);
    strb.polToLow  = wrEn && (topByte == KEY_POL_LOW);
    strb.drvToPush = wrEn && (topByte == KEY_DRV_PUSH);
    strb.drvToOpen = wrEn && (topByte == KEY_DRV_OPEN);
    unique case (state)
      ST_IDLE: begin
        if (expire) begin
          strb.loadCount = 1'b1;
          stateNext = ST_DRIVE;
        end
      end
      ST_DRIVE: begin
        if (tick) begin
          if (countZero) stateNext = ST_IDLE;
          else strb.decCount = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  assign active = (state == ST_DRIVE);

  // R6: a strobe while idle starts the pulse on the next edge
  assert_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!active && expire) |=> active);

  // R6: the last tick at count zero ends the pulse
  assert_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    (active && tick && countZero) |=> !active);

  // R7: without a tick, nothing ends or restarts a running pulse
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (active && !tick) |=> active);

endmodule

// File: rtl/extrst_datapath.sv
module extrst_datapath
  import extrst_pkg::*;
#(
  parameter int WIDTH_BITS = 20,
  parameter int DATA_W     = 32,
  parameter logic [WIDTH_BITS-1:0] RST_WIDTH = 'hFF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobes_t            strb,
  input  logic [WIDTH_BITS-1:0] wrWidth,
  input  logic                  active,
  output logic [DATA_W-1:0]     rdData,
  output logic                  countZero,
  output logic                  pulseOut,
  output logic                  pulseOe
);

  localparam int PAD_W = DATA_W - 2 - WIDTH_BITS;

  logic [WIDTH_BITS-1:0] widthReg;
  logic [WIDTH_BITS-1:0] pulseCount;
  logic                  polHigh;
  logic                  pushPull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthReg <= RST_WIDTH;
      polHigh  <= 1'b0;
      pushPull <= 1'b0;
    end else begin
      if (strb.loadWidth) widthReg <= wrWidth;
      if (strb.polToHigh) polHigh <= 1'b1;
      else if (strb.polToLow) polHigh <= 1'b0;
      if (strb.drvToPush) pushPull <= 1'b1;
      else if (strb.drvToOpen) pushPull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseCount <= '0;
    else if (strb.loadCount) pulseCount <= widthReg;
    else if (strb.decCount) pulseCount <= pulseCount - 1'b1;
  end

  assign countZero = (pulseCount == '0);
  assign rdData    = {polHigh, pushPull, {PAD_W{1'b0}}, widthReg};
  assign pulseOut  = active ? polHigh : ~polHigh;
  assign pulseOe   = pushPull | active;

  // R6: each counted tick moves the counter down by exactly one
  assert_dec_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.decCount |=> (pulseCount == $past(pulseCount) - 1'b1));

  // R10: a start copies the length present at the start
  assert_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCount |=> (pulseCount == $past(widthReg)));

endmodule

// File: rtl/extrst_pulse_gen.sv
module extrst_pulse_gen
  import extrst_pkg::*;
#(
  parameter int WIDTH_BITS = 20,
  parameter int DATA_W     = 32,
  parameter logic [WIDTH_BITS-1:0] RST_WIDTH = 'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              expire,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              pulseOut,
  output logic              pulseOe
);

  localparam int TOP_LO = DATA_W - 8;

  dpStrobes_t strb;
  logic       activeW;
  logic       countZeroW;
  logic [7:0] topByte;
  logic       unusedBits;

  assign topByte    = wrData[DATA_W-1:TOP_LO];
  assign unusedBits = ^wrData[TOP_LO-1:WIDTH_BITS];

  extrst_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .expire    (expire),
    .tick      (tick),
    .wrEn      (wrEn),
    .topByte   (topByte),
    .countZero (countZeroW),
    .strb      (strb),
    .active    (activeW)
  );

  extrst_datapath #(
    .WIDTH_BITS (WIDTH_BITS),
    .DATA_W     (DATA_W),
    .RST_WIDTH  (RST_WIDTH)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrWidth   (wrData[WIDTH_BITS-1:0]),
    .active    (activeW),
    .rdData    (rdData),
    .countZero (countZeroW),
    .pulseOut  (pulseOut),
    .pulseOe   (pulseOe)
  );

  // R2: the written length is what reads back
  assert_width_store_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData[WIDTH_BITS-1:0] == $past(wrData[WIDTH_BITS-1:0])));

  // R5: an unkeyed top byte keeps polarity and drive
  assert_key_guard_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && topByte != KEY_POL_HIGH && topByte != KEY_POL_LOW &&
     topByte != KEY_DRV_PUSH && topByte != KEY_DRV_OPEN)
    |=> $stable(rdData[DATA_W-1:DATA_W-2]));

  // R8: the asserted pin level follows the polarity bit
  assert_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    activeW |-> (pulseOut == rdData[DATA_W-1]));

  // R9: open drain releases the pin while idle
  assert_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!activeW && !rdData[DATA_W-2]) |-> !pulseOe);

endmodule

// File: tb/test_extrst_pulse_gen.sv
module test_extrst_pulse_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        expire = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        pulseOut;
  logic        pulseOe;

  int  nChecks = 0;
  int  nFails = 0;
  bit  expPol = 1'b0;
  bit  expPush = 1'b0;

  always #4 clk = ~clk;

  extrst_pulse_gen i_extrst_pulse_gen (
    .clk      (clk),
    .rstN     (rstN),
    .expire   (expire),
    .tick     (tick),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .rdData   (rdData),
    .pulseOut (pulseOut),
    .pulseOe  (pulseOe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [31:0] d);
    wrEn = 1'b1;
    wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  // Runs one pulse and returns the number of ticks seen while it was asserted.
  task automatic runPulse(input int tickEvery, input bit extraStrobe,
                          input bit midWrite, output int ticks);
    int badCyc = 0;
    bit firstOk;
    ticks = 0;
    check(pulseOut == !expPol && pulseOe == expPush, "R8 idle level before pulse",
          {30'd0, pulseOut, pulseOe}, {30'd0, !expPol, expPush});
    expire = 1'b1;
    tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    expire = 1'b0;
    tick = 1'b0;
    firstOk = (pulseOut == expPol);
    check(firstOk, "R6 pulse asserted cycle after strobe", {31'd0, pulseOut},
          {31'd0, expPol});
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (pulseOut != expPol) break;
      if (pulseOe != 1'b1) badCyc++;
      tick = (cyc % tickEvery) == 0;
      if (tick) ticks++;
      expire = extraStrobe && ((cyc % 2) == 1);
      if (midWrite && cyc == 1) begin
        wrEn = 1'b1;
        wrData = 32'h0000_0001;
      end
      @(posedge clk);
      @(negedge clk);
      tick = 1'b0;
      expire = 1'b0;
      wrEn = 1'b0;
      wrData = '0;
    end
    check(badCyc == 0, "R9 output enabled while asserted", badCyc, 0);
    check(pulseOut == !expPol && pulseOe == expPush, "R9 idle level after pulse",
          {30'd0, pulseOut, pulseOe}, {30'd0, !expPol, expPush});
  endtask

  task automatic testReset();
    check(rdData == 32'h0000_00FF, "R1 reset read word", rdData, 32'h0000_00FF);
    check(pulseOut == 1'b1 && pulseOe == 1'b0, "R1 reset pin state",
          {30'd0, pulseOut, pulseOe}, 32'h2);
  endtask

  task automatic testRegs();
    regWrite(32'h000A_BCDE);
    check(rdData == 32'h000A_BCDE, "R2 length stored", rdData, 32'h000A_BCDE);
    regWrite(32'h3FFF_FFFF);
    check(rdData == 32'h000F_FFFF, "R2 bits 29:20 read zero", rdData, 32'h000F_FFFF);
  endtask

  task automatic testPolarity();
    regWrite(32'hA500_0010);
    check(rdData == 32'h8000_0010, "R3 key A5 sets high", rdData, 32'h8000_0010);
    regWrite(32'h5A00_0011);
    check(rdData == 32'h0000_0011, "R3 key 5A sets low", rdData, 32'h0000_0011);
  endtask

  task automatic testDrive();
    regWrite(32'hA800_0020);
    check(rdData == 32'h4000_0020, "R4 key A8 sets push-pull", rdData, 32'h4000_0020);
    check(pulseOe == 1'b1, "R9 push-pull idle enable", {31'd0, pulseOe}, 32'h1);
    regWrite(32'h8A00_0021);
    check(rdData == 32'h0000_0021, "R4 key 8A sets open-drain", rdData, 32'h0000_0021);
    check(pulseOe == 1'b0, "R9 open-drain idle release", {31'd0, pulseOe}, 32'h0);
  endtask

  task automatic testKeyGuard();
    regWrite(32'hA500_0000);
    regWrite(32'hA800_0000);
    regWrite(32'hA600_0123);
    check(rdData == 32'hC000_0123, "R5 near-key A6 ignored", rdData, 32'hC000_0123);
    regWrite(32'h5500_0456);
    check(rdData == 32'hC000_0456, "R5 byte 55 ignored", rdData, 32'hC000_0456);
    regWrite(32'h8B00_0789);
    check(rdData == 32'hC000_0789, "R5 near-key 8B ignored", rdData, 32'hC000_0789);
    check(pulseOut == 1'b0 && pulseOe == 1'b1, "R5 pin idle state unchanged",
          {30'd0, pulseOut, pulseOe}, 32'h1);
    regWrite(32'h5A00_0000);
    regWrite(32'h8A00_0000);
  endtask

  task automatic testLengths();
    int t;
    expPol = 1'b0; expPush = 1'b0;
    regWrite(32'h0000_0000);
    runPulse(1, 1'b0, 1'b0, t);
    check(t == 1, "R6 length 0 gives 1 tick", t, 1);
    regWrite(32'h0000_0003);
    runPulse(3, 1'b0, 1'b0, t);
    check(t == 4, "R6 length 3 sparse ticks", t, 4);
    regWrite(32'h0000_00FF);
    runPulse(1, 1'b0, 1'b0, t);
    check(t == 256, "R6 length 0xFF gives 256 ticks", t, 256);
  endtask

  task automatic testRetrigger();
    int t;
    regWrite(32'h0000_0004);
    runPulse(2, 1'b1, 1'b0, t);
    check(t == 5, "R7 extra strobes do not extend", t, 5);
    @(posedge clk);
    @(negedge clk);
    check(pulseOut == 1'b1, "R7 no restart after end", {31'd0, pulseOut}, 32'h1);
  endtask

  task automatic testHighPush();
    int t;
    regWrite(32'hA500_0002);
    regWrite(32'hA800_0002);
    expPol = 1'b1; expPush = 1'b1;
    runPulse(2, 1'b0, 1'b0, t);
    check(t == 3, "R8 active-high push-pull length", t, 3);
    regWrite(32'h8A00_0002);
    expPush = 1'b0;
    runPulse(1, 1'b0, 1'b0, t);
    check(t == 3, "R9 active-high open-drain length", t, 3);
    regWrite(32'h5A00_0002);
    expPol = 1'b0;
  endtask

  task automatic testMidWrite();
    int t;
    regWrite(32'h0000_0006);
    runPulse(1, 1'b0, 1'b1, t);
    check(t == 7, "R10 mid-pulse write ignored by pulse", t, 7);
    check(rdData == 32'h0000_0001, "R10 mid-pulse write stored", rdData, 32'h1);
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testPolarity();
    testDrive();
    testKeyGuard();
    testLengths();
    testRetrigger();
    testHighPush();
    testMidWrite();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule